// File: doc/BRIEF.md
# Modulo Timer with Interlocked Overflow Flag

The block is a 16-bit up-counter with a prescaler. The counter wraps to zero once it has reached a programmable modulo value. A byte-wide CPU bus gives access to a control/status register, the two modulo bytes and the two count bytes. The bus has an address, a read strobe, a write strobe, write data and combinational read data. The control/status register holds four things: an overflow flag, an overflow interrupt enable, a halt bit, and a self-clearing counter-zero command. It also holds a 3-bit divider code. The interrupt request output is high while the overflow flag and its enable are both set.

The overflow flag can only be cleared by a two-step handshake. Software first reads the control/status register while the flag is set, which arms the clear. Software then writes that register with bit 7 at zero. A small state machine tracks the handshake. It has two states: `CLR_IDLE` (not armed) and `CLR_ARMED` (armed).

- **arm** (`CLR_IDLE` → `CLR_ARMED`): a strobed read of the register that sees the flag set, with no wrap in the same cycle.
- **disarm** (`CLR_ARMED` → `CLR_IDLE`): any write to the register, or any counter wrap.

A wrap in the window between the read and the write therefore defeats the clear, so no overflow event is lost. After reset the counter is halted until software clears the halt bit.

Top module: `modtmr_top`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x20, the modulo bytes (addresses 1 high, 2 low) read 0xFF, the count bytes (addresses 3 high, 4 low) read 0x00, and irq is 0.
- R2: With halt at 0 and divider code 0, the count advances by one on every clock. On a tick where the count equals the modulo value, the count becomes 0x0000.
- R3: The overflow flag (bit 7) becomes 1 on the same clock edge at which the count wraps to zero.
- R4: A strobed read of address 0 that sees bit 7 set, followed later by a write to address 0 with bit 7 at 0, clears the flag. No wrap and no other write to address 0 may occur in between.
- R5: A write of 0 to bit 7 that was not preceded by such an arming read leaves the flag set.
- R6: If the count wraps after the arming read and before the clearing write, the flag stays set after that write.
- R7: Writing 1 to bit 7 never sets the flag. Any write to address 0 cancels a pending arm.
- R8: irq equals the flag (bit 7) AND the interrupt enable (bit 6) on every cycle.
- R9: While the halt bit (bit 5) is 1, the count holds its value. Counting resumes from that value when halt is cleared.
- R10: The divider code (bits 2..0) makes the count tick once every 2^code clocks for codes 0 to 6, and once every 64 clocks for code 7. The prescaler counts from zero after a counter-zero command.
- R11: Writing 1 to bit 4 of address 0 clears the count and the prescaler at that clock edge. Bits 4 and 3 always read 0.
- R12: Addresses 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, arms the flag clear when at address 0 |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same cycle. They also assume that bus inputs change only between clock edges, so every strobe is seen for exactly one edge. The bench drives each access at the falling edge as a single-cycle strobe and never combines reads and writes. It checks the result through combinational read data before the next edge. Where the counter runs freely, an overflow may land on the arming or clearing edge. The expected flag value in those cases comes from the bench's own reference model rather than from a fixed constant.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int CNT_W   = 2 * DATA_W;
    localparam int SEL_W   = 3;
    localparam int MAX_LOG = 6;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODH = 3'd1;
    localparam logic [ADDR_W-1:0] A_MODL = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNTH = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNTL = 3'd4;

    localparam int B_OVF  = 7;
    localparam int B_OIE  = 6;
    localparam int B_HALT = 5;
    localparam int B_ZERO = 4;

    typedef enum logic {
        CLR_IDLE  = 1'b0,
        CLR_ARMED = 1'b1
    } clr_state_e;
endpackage

// File: rtl/modtmr_presc.sv
module modtmr_presc #(
    parameter int MAX_LOG = 6,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [MAX_LOG-1:0] pre_q;
    logic [MAX_LOG-1:0] mask;

    // codes above MAX_LOG saturate: every mask bit set
    always_comb begin
        mask = '0;
        for (int i = 0; i < MAX_LOG; i++) begin
            mask[i] = (int'(sel) > i);
        end
    end

    assign tick = run && ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/modtmr_count.sv
module modtmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] modv,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap = tick && (cnt_q == modv);
    assign cnt  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/modtmr_regs.sv
module modtmr_regs
    import modtmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wrap,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata,
    output logic              ovf,
    output logic              oie,
    output logic              halt,
    output logic [SEL_W-1:0]  sel,
    output logic              zero_cmd,
    output logic [CNT_W-1:0]  modv,
    output logic              irq
);
    clr_state_e state_q, state_d;
    logic       clr_ok;
    logic       wr_ctrl, rd_ctrl;
    logic       ovf_q, oie_q, halt_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] mod_q;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign rd_ctrl = rd_en && (addr == A_CTRL);

    // clear-handshake state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CLR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm / disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLR_IDLE: begin
                if (rd_ctrl && ovf_q && !wrap && !wr_ctrl) begin
                    state_d = CLR_ARMED;
                end
            end
            CLR_ARMED: begin
                if (wr_ctrl || wrap) begin
                    state_d = CLR_IDLE;
                end
            end
        endcase
    end

    // outputs of the handshake
    always_comb begin
        clr_ok = 1'b0;
        unique case (state_q)
            CLR_IDLE:  clr_ok = 1'b0;
            CLR_ARMED: clr_ok = wr_ctrl && !wdata[B_OVF];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (wrap) begin
            ovf_q <= 1'b1;
        end else if (clr_ok) begin
            ovf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oie_q  <= 1'b0;
            halt_q <= 1'b1;
            sel_q  <= '0;
        end else if (wr_ctrl) begin
            oie_q  <= wdata[B_OIE];
            halt_q <= wdata[B_HALT];
            sel_q  <= wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q <= '1;
        end else if (wr_en && (addr == A_MODH)) begin
            mod_q[CNT_W-1:DATA_W] <= wdata;
        end else if (wr_en && (addr == A_MODL)) begin
            mod_q[DATA_W-1:0] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_OVF]       = ovf_q;
                rdata[B_OIE]       = oie_q;
                rdata[B_HALT]      = halt_q;
                rdata[SEL_W-1:0]   = sel_q;
            end
            A_MODH:  rdata = mod_q[CNT_W-1:DATA_W];
            A_MODL:  rdata = mod_q[DATA_W-1:0];
            A_CNTH:  rdata = cnt[CNT_W-1:DATA_W];
            A_CNTL:  rdata = cnt[DATA_W-1:0];
            default: rdata = '0;
        endcase
    end

    assign zero_cmd = wr_ctrl && wdata[B_ZERO];
    assign ovf      = ovf_q;
    assign oie      = oie_q;
    assign halt     = halt_q;
    assign sel      = sel_q;
    assign modv     = mod_q;
    assign irq      = ovf_q && oie_q;
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
    import modtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic             tick, wrap, zero_cmd;
    logic             ovf_flag, oie, halt;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt, modv;

    modtmr_presc #(.MAX_LOG(MAX_LOG), .SEL_W(SEL_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (!halt),
        .clr  (zero_cmd),
        .sel  (sel),
        .tick (tick)
    );

    modtmr_count #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (zero_cmd),
        .modv (modv),
        .cnt  (cnt),
        .wrap (wrap)
    );

    modtmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .wrap    (wrap),
        .cnt     (cnt),
        .rdata   (rdata),
        .ovf     (ovf_flag),
        .oie     (oie),
        .halt    (halt),
        .sel     (sel),
        .zero_cmd(zero_cmd),
        .modv    (modv),
        .irq     (irq)
    );
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk
    import modtmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              ovf,
    input logic              halt,
    input logic              wrap,
    input logic [CNT_W-1:0]  cnt
);
    logic wr_ctrl;
    assign wr_ctrl = wr_en && (addr == A_CTRL);

    a_r3_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf);

    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    a_r4_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf) |-> $past(wr_ctrl && !wdata[B_OVF]));

    a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf && !wrap) |=> !ovf);

    a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !wr_ctrl) |=> $stable(cnt));

    a_r11_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[B_ZERO]) |=> (cnt == '0));
endmodule

bind modtmr_top modtmr_chk #(.CNT_W(modtmr_pkg::CNT_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .addr (addr),
    .wdata(wdata),
    .ovf  (ovf_flag),
    .halt (halt),
    .wrap (wrap),
    .cnt  (cnt)
);

// File: tb/sim_modtmr_top.sv
`timescale 1ns/1ps
module sim_modtmr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    modtmr_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // behavioural reference model
    logic [15:0] m_cnt, m_mod;
    logic [5:0]  m_pre;
    logic        m_tof, m_toie, m_stop, m_arm;
    logic [2:0]  m_ps;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mod = 16'hFFFF; m_pre = 0; m_tof = 0;
            m_toie = 0; m_stop = 1; m_arm = 0; m_ps = 0;
        end else begin
            int  shift, mask;
            bit  tk, wrp, wsc, rsc;
            shift = (m_ps > 6) ? 6 : int'(m_ps);
            mask  = (1 << shift) - 1;
            tk    = !m_stop && ((int'(m_pre) & mask) == mask);
            wrp   = tk && (m_cnt == m_mod);
            wsc   = wr_en && addr == 3'd0;
            rsc   = rd_en && addr == 3'd0;
            if (wrp) m_tof = 1;
            else if (wsc && m_arm && !wdata[7]) m_tof = 0;
            if (wsc || wrp) m_arm = 0;
            else if (rsc && m_tof) m_arm = 1;
            if (wsc && wdata[4]) begin
                m_cnt = 0; m_pre = 0;
            end else begin
                if (!m_stop) m_pre = m_pre + 1;
                if (tk) m_cnt = wrp ? 16'd0 : m_cnt + 1;
            end
            if (wsc) begin
                m_toie = wdata[6]; m_stop = wdata[5]; m_ps = wdata[2:0];
            end
            if (wr_en && addr == 3'd1) m_mod[15:8] = wdata;
            if (wr_en && addr == 3'd2) m_mod[7:0]  = wdata;
        end
    end

    function automatic logic [7:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return {m_tof, m_toie, m_stop, 2'b00, m_ps};
            3'd1: return m_mod[15:8];
            3'd2: return m_mod[7:0];
            3'd3: return m_cnt[15:8];
            3'd4: return m_cnt[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check8(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // irq compared with the model on every clock (R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== (m_tof && m_toie)) begin
                fails++;
                $display("FAIL R8: irq got %b expected %b", irq, m_tof && m_toie);
            end
        end
    end

    task automatic bus(input logic w, input logic r, input logic [2:0] a,
                       input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        if (!w) check8(rdata, model_rd(a), tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) bus(0, 0, 3'd4, 8'h00, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        bus(0, 0, 3'd0, 0, "R1"); check8(rdata, 8'h20, "R1");
        check8({7'd0, irq}, 8'h00, "R1");
        bus(0, 0, 3'd1, 0, "R1"); check8(rdata, 8'hFF, "R1");
        bus(0, 0, 3'd2, 0, "R1"); check8(rdata, 8'hFF, "R1");
        bus(0, 0, 3'd3, 0, "R1"); check8(rdata, 8'h00, "R1");
        bus(0, 0, 3'd4, 0, "R1"); check8(rdata, 8'h00, "R1");

        // R2 counting, modulo 5
        bus(1, 0, 3'd1, 8'h00, "R2");
        bus(1, 0, 3'd2, 8'h05, "R2");
        bus(1, 0, 3'd0, 8'h00, "R2");
        idle(3, "R2"); check8(rdata, 8'd2, "R2");
        idle(10, "R2");
        // R3 flag after wrap
        bus(0, 0, 3'd0, 0, "R3"); check8(rdata & 8'h80, 8'h80, "R3");

        // R5 unarmed write of 0 (also halts)
        bus(1, 0, 3'd0, 8'h20, "R5");
        bus(0, 0, 3'd0, 0, "R5"); check8(rdata, 8'hA0, "R5");
        // R7 write of 1
        bus(1, 0, 3'd0, 8'hA0, "R7");
        bus(0, 0, 3'd0, 0, "R7"); check8(rdata, 8'hA0, "R7");
        // R4 armed clear
        bus(0, 1, 3'd0, 0, "R4");
        bus(1, 0, 3'd0, 8'h20, "R4");
        bus(0, 0, 3'd0, 0, "R4"); check8(rdata, 8'h20, "R4");

        // R6 overflow inside window
        bus(1, 0, 3'd2, 8'h03, "R6");
        bus(1, 0, 3'd0, 8'h00, "R6");
        idle(8, "R6");
        bus(0, 1, 3'd0, 0, "R6");
        idle(5, "R6");
        bus(1, 0, 3'd0, 8'h20, "R6");
        bus(0, 0, 3'd0, 0, "R6"); check8(rdata & 8'h80, 8'h80, "R6");
        bus(0, 1, 3'd0, 0, "R4");
        bus(1, 0, 3'd0, 8'h20, "R4");
        bus(0, 0, 3'd0, 0, "R4"); check8(rdata, 8'h20, "R4");

        // R8 interrupt
        bus(1, 0, 3'd0, 8'h40, "R8");
        idle(8, "R8"); check8({7'd0, irq}, 8'h01, "R8");
        bus(1, 0, 3'd0, 8'h60, "R8");
        bus(1, 0, 3'd0, 8'h20, "R8");
        bus(0, 0, 3'd0, 0, "R8"); check8({7'd0, irq}, 8'h00, "R8");

        // R9 halt holds, then resumes
        bus(0, 0, 3'd4, 0, "R9"); held = rdata;
        idle(10, "R9"); check8(rdata, held, "R9");
        bus(1, 0, 3'd0, 8'h00, "R9");
        idle(4, "R9");

        // R10 divider codes
        bus(1, 0, 3'd1, 8'hFF, "R10");
        bus(1, 0, 3'd2, 8'hFF, "R10");
        for (int ps = 0; ps < 8; ps++) begin
            bus(1, 0, 3'd0, 8'h10 | 8'(ps), "R10");
            idle(130, "R10");
            if (ps == 0) check8(rdata, 8'd129, "R10");
            if (ps == 3) check8(rdata, 8'd16, "R10");
            if (ps == 6) check8(rdata, 8'd2, "R10");
            if (ps == 7) check8(rdata, 8'd2, "R10");
        end

        // R11 counter-zero command
        bus(1, 0, 3'd0, 8'h30, "R11");
        bus(0, 0, 3'd0, 0, "R11"); check8(rdata & 8'h18, 8'h00, "R11");
        bus(0, 0, 3'd4, 0, "R11"); check8(rdata, 8'h00, "R11");
        bus(0, 0, 3'd3, 0, "R11"); check8(rdata, 8'h00, "R11");

        // R12 unused addresses
        for (int a = 5; a < 8; a++) begin
            bus(0, 0, 3'(a), 0, "R12"); check8(rdata, 8'h00, "R12");
        end

        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule